// File: doc/BRIEF.md
# Periodic Interrupt Divider

This block turns a free-running 32.768 kHz tick strobe into a periodic interrupt request. A 4-bit rate code selects a period that is a power of two of the tick. Each time a free-running tick count crosses a multiple of that period, the block emits a one-cycle set pulse. The surrounding status register uses that pulse to set its periodic flag and its interrupt-request flag, which are the top two bits of the flag byte.

The rate code and an enable bit come from the control registers. They are captured only when the configuration write strobe is high. Because the tick count is never cleared by a reconfiguration, pulses always land on period boundaries of that count, whatever setting was active before.

Top module: `periodic_irq_div`

## Requirements
- R1: After a synchronous active-low reset, `flag_set_o` is 0, the tick count is 0 and the generator is disabled (captured code 6, enable 0). Once enabled with code C, the first pulse follows the tick that brings the count to one full period.
- R2: While the captured rate code is 0, or the captured enable is 0, `flag_set_o` stays 0 for every tick.
- R3: For captured codes 3 to 15, the period is 2^(code-1) ticks: 4 ticks for code 3 and 16384 ticks for code 15.
- R4: Captured code 1 gives a period of 128 ticks and code 2 gives 256 ticks, the same periods as codes 8 and 9.
- R5: `flag_set_o` is high for exactly one cycle. That cycle follows the clock edge at which `tick_i` was sampled high and the incremented count became a multiple of the period.
- R6: `rate_code_i` and `pie_en_i` are captured only at an edge where `cfg_wr_i` is 1. Changes on them at other times have no effect on `flag_set_o`. A tick at the same edge as a write uses the previous setting.
- R7: A new setting takes effect at the next boundary of the new period on the running count. The count is not cleared by a write.
- R8: The count is 15 bits wide. It wraps from 32767 to 0, and that wrap is a boundary for every period.
- R9: On an edge where `tick_i` is 0, the count holds and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per 32.768 kHz tick |
| cfg_wr_i | input | 1 | Capture rate code and enable at this edge |
| rate_code_i | input | 4 | Rate code, 0 stops the generator |
| pie_en_i | input | 1 | Periodic interrupt enable |
| flag_set_o | output | 1 | One-cycle pulse setting the periodic and request flags |

## Verification
The assertions check four things on every cycle: no pulse ever comes out while the captured setting is idle, every pulse traces back to a sampled tick, pulses never occur back to back, and the count steps by one per tick and holds otherwise. Only the bench's scenarios can show the exact period for each code, the aliasing of codes 1 and 2, the alignment after a mid-run rate change, and the wrap boundary. To do so, the bench sweeps every code with a model of the count that it keeps itself.

// File: rtl/periodic_irq_pkg.sv
// Shared types and the rate-code aliasing rule for the periodic divider.
// Assumes a 4-bit rate code; the count width is chosen by the top.
package periodic_irq_pkg;
    localparam int CODE_W = 4;
    typedef logic [CODE_W-1:0] rate_code_t;

    // Map the two fast-looking codes onto the slow rates they alias to.
    function automatic rate_code_t effective_code(input rate_code_t code);
        case (code)
            rate_code_t'(1): return rate_code_t'(8);
            rate_code_t'(2): return rate_code_t'(9);
            default:         return code;
        endcase
    endfunction
endpackage

// File: rtl/periodic_rate_decode.sv
// Turns the captured setting into an activity flag and a boundary mask.
// The mask has the low (effective code - 1) bits set, so a count value is on a
// period boundary when it has no bits under the mask. Purely combinational.
module periodic_rate_decode
    import periodic_irq_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  rate_code_t       code_i,
    input  logic             en_i,
    output logic             active_o,
    output logic [CNT_W-1:0] mask_o
);
    rate_code_t eff;
    int         shift;

    // Derive activity and the low-bit mask from the effective code.
    always_comb begin
        eff      = effective_code(code_i);
        shift    = int'(eff) - 1;
        active_o = en_i && (code_i != '0);
        for (int i = 0; i < CNT_W; i++) begin
            mask_o[i] = active_o && (i < shift);
        end
    end
endmodule

// File: rtl/tick_counter.sv
// Free-running tick count that wraps naturally at its width.
// Assumes tick_i is a single-cycle strobe; reset is synchronous, active low.
module tick_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt_next_o = cnt_q + CNT_W'(1);
    assign cnt_o      = cnt_q;

    // Advance the count on each tick, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_next_o;
    end

    p_count_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    p_count_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/periodic_irq_div.sv
// Periodic interrupt divider: captures rate code and enable on a write strobe.
// It pulses flag_set_o for one cycle after any tick that lands the free count
// on a multiple of 2^(effective code - 1). Assumes one tick per 32.768 kHz
// period and a synchronous active-low reset.
module periodic_irq_div
    import periodic_irq_pkg::*;
#(
    parameter int CNT_W      = 15,
    parameter int RST_CODE   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cfg_wr_i,
    input  logic [CODE_W-1:0] rate_code_i,
    input  logic              pie_en_i,
    output logic              flag_set_o
);
    rate_code_t       code_q;
    logic             en_q;
    logic             active;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             pulse_q;

    // Capture the setting only when software writes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= rate_code_t'(RST_CODE);
            en_q   <= 1'b0;
        end else if (cfg_wr_i) begin
            code_q <= rate_code_i;
            en_q   <= pie_en_i;
        end
    end

    periodic_rate_decode #(.CNT_W(CNT_W)) u_decode (
        .code_i   (code_q),
        .en_i     (en_q),
        .active_o (active),
        .mask_o   (mask)
    );

    tick_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .cnt_o      (cnt),
        .cnt_next_o (cnt_next)
    );

    // Register the boundary hit so the set pulse is one clean cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= active && tick_i && ((cnt_next & mask) == '0);
    end

    assign flag_set_o = pulse_q;

    p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q || code_q == '0) |=> !flag_set_o);

    p_pulse_from_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set_o |-> $past(tick_i));

    p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set_o |=> !flag_set_o);

    p_capture_only_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> ($stable(code_q) && $stable(en_q)));
endmodule

// File: tb/tb_periodic_irq_div.sv
module tb_periodic_irq_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [3:0] rate_code_i = 4'd0;
    logic       pie_en_i = 1'b0;
    logic       flag_set_o;

    int total = 0;
    int bad = 0;
    int m_code = 6;
    int m_en = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    periodic_irq_div dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_wr_i(cfg_wr_i),
        .rate_code_i(rate_code_i), .pie_en_i(pie_en_i), .flag_set_o(flag_set_o)
    );

    function automatic int period_of(input int code);
        int e;
        e = (code == 1) ? 8 : (code == 2) ? 9 : code;
        return 1 << (e - 1);
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: flag_set_o=%0b expected=%0b (code=%0d en=%0d cnt=%0d)",
                     req, act, exp, m_code, m_en, m_cnt);
        end
    endtask

    // One clock step from a negedge; checks the pulse caused by this edge.
    task automatic step(input logic tk, input logic wr, input int code,
                        input logic en, input string req);
        logic exp;
        int nxt;
        tick_i = tk; cfg_wr_i = wr; rate_code_i = 4'(code); pie_en_i = en;
        nxt = tk ? (m_cnt + 1) % 32768 : m_cnt;
        exp = tk && m_en != 0 && m_code != 0 && (nxt % period_of(m_code) == 0);
        if (wr) begin m_code = code; m_en = en; end
        m_cnt = nxt;
        @(posedge clk);
        @(negedge clk);
        check(flag_set_o, exp, req);
        tick_i = 1'b0; cfg_wr_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_code = 6; m_en = 0; m_cnt = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state, disabled generator stays silent on ticks
        check(flag_set_o, 1'b0, "R1");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 0, 1'b0, "R1");

        // R3 R4 R8: sweep every code from reset over two periods plus a few ticks
        for (int c = 0; c < 16; c++) begin
            string tag;
            int n;
            tag = (c == 1 || c == 2) ? "R4" : (c == 0) ? "R2" : (c == 15) ? "R8" : "R3";
            do_reset();
            step(1'b0, 1'b1, c, 1'b1, "R1");
            n = (c == 0) ? 300 : 2 * period_of(c) + 3;
            for (int i = 0; i < n; i++) step(1'b1, 1'b0, c, 1'b1, tag);
        end

        // R2: enable low with a nonzero code
        do_reset();
        step(1'b0, 1'b1, 3, 1'b0, "R2");
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 3, 1'b0, "R2");

        // R9 R5: sparse ticks, pulse only after ticking edges
        do_reset();
        step(1'b0, 1'b1, 3, 1'b1, "R9");
        for (int i = 0; i < 60; i++) step((i % 3) == 0, 1'b0, 3, 1'b1, "R9");

        // R6: inputs wiggle without the strobe; setting must not change
        do_reset();
        step(1'b0, 1'b1, 4, 1'b1, "R6");
        for (int i = 0; i < 50; i++) step(1'b1, 1'b0, 3 + (i % 2), (i % 4) != 1, "R6");
        // R6: tick coinciding with a write uses the old setting
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 0, 1'b0, "R6");
        step(1'b1, 1'b1, 3, 1'b1, "R6");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 3, 1'b1, "R6");

        // R7: change rate mid-count, no counter clear
        do_reset();
        step(1'b0, 1'b1, 3, 1'b1, "R7");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 3, 1'b1, "R7");
        step(1'b0, 1'b1, 4, 1'b1, "R7");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 4, 1'b1, "R7");
        step(1'b0, 1'b1, 1, 1'b1, "R7");
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 1, 1'b1, "R7");
        step(1'b0, 1'b1, 3, 1'b0, "R2");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 3, 1'b0, "R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule